// File: doc/BRIEF.md
# Set-Associative Trace Prediction Table

This block holds descriptors of instruction traces that a speculative core may skip. Before speculation begins, a loader writes descriptors into the table through a fill port. Each descriptor holds the following fields:

- the trace's starting PC;
- the PC at which the trace ends;
- a branch-history signature;
- up to `LIVE_N` predicted live-output register/value pairs;
- an initial confidence count.

At run time the core presents its current PC and branch history. One cycle later the table reports whether a trace starts here. On a hit it also returns the end PC and the predicted live outputs, so the instructions in between can be bypassed.

A feedback port reports whether a prediction proved correct. Each entry keeps a small saturating confidence counter. Correct predictions raise it and misspeculations lower it. An entry whose counter has fallen to zero stays stored but is no longer offered as a prediction. When a fill lands in a set with no free way, the counter also selects the way to evict.

Top module: `trace_table`

## Requirements
- R1: After reset no entry is valid: `respValid` is low until a lookup is made, and every lookup misses.
- R2: `respValid` is high in exactly the cycle after a cycle with `lookValid` high, and low otherwise.
- R3: A lookup hits only when a valid entry has the same PC tag and set as `lookPc` and a stored history equal to `lookHist`. On a hit, `respEndPc`, `respRegs`, `respVals` and `respLive` return that entry's stored values. Pair i occupies `respRegs[i*REG_W +: REG_W]`, `respVals[i*DATA_W +: DATA_W]` and `respLive[i]`.
- R4: On a miss, `respEndPc`, `respRegs`, `respVals` and `respLive` are all zero.
- R5: The set is selected by `PC[ALIGN +: log2(SETS)]`, and the bits above that are the tag. The lowest `ALIGN` PC bits are ignored.
- R6: An entry whose confidence counter is zero is never reported as a hit.
- R7: Feedback that names a stored entry (same PC and history) adjusts its counter. A correct prediction adds one, saturating at the all-ones value. A misspeculation subtracts one, saturating at zero.
- R8: A fill whose PC and history match a stored entry overwrites that entry. Otherwise the fill takes the lowest-numbered free way of the set. If the set is full, it replaces the way with the smallest counter, with ties going to the lowest way number.
- R9: A fill loads the entry's counter from `fillFreq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fillValid | input | 1 | Write a descriptor this cycle |
| fillPc | input | PC_W | Starting PC of the trace |
| fillEndPc | input | PC_W | End PC of the trace |
| fillHist | input | HIST_W | Branch-history signature |
| fillRegs | input | LIVE_N*REG_W | Live-output register numbers |
| fillVals | input | LIVE_N*DATA_W | Live-output predicted values |
| fillLive | input | LIVE_N | Valid bit per live-output pair |
| fillFreq | input | CNT_W | Initial confidence count |
| lookValid | input | 1 | Lookup request |
| lookPc | input | PC_W | Current PC |
| lookHist | input | HIST_W | Current branch history |
| respValid | output | 1 | Lookup result present |
| respHit | output | 1 | Trace predicted |
| respEndPc | output | PC_W | Predicted end PC |
| respRegs | output | LIVE_N*REG_W | Predicted live-output registers |
| respVals | output | LIVE_N*DATA_W | Predicted live-output values |
| respLive | output | LIVE_N | Live-output pair valid bits |
| fbValid | input | 1 | Feedback present |
| fbPc | input | PC_W | Starting PC of the judged trace |
| fbHist | input | HIST_W | History of the judged trace |
| fbCorrect | input | 1 | 1 for a correct prediction, 0 for a misspeculation |

## Verification
The bench builds the table with the following parameters:

- 4 sets of 4 ways;
- 16-bit PCs and values;
- 4-bit histories;
- two live-output pairs;
- 2-bit counters.

With 2-bit counters, both saturation limits can be reached with a handful of feedback events. With only four sets, a single set can be filled and overflowed with five descriptors, so the tie-breaking eviction rule and the overwrite-on-match rule can be exercised directly. The short PCs keep distinct tags that share a set easy to construct, which is what the history and tag mismatch cases need.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  typedef struct packed {
    logic fillWe;
    logic fbInc;
    logic fbDec;
    logic lookCap;
    logic lookHit;
  } ttbStrobe_t;
endpackage

// File: rtl/ttb_ctrl.sv
module ttb_ctrl
  import ttb_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int SETS   = 32,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 4,
  parameter int ALIGN  = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = PC_W - IDX_W - ALIGN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lookValid,
  input  logic [PC_W-1:0]   lookPc,
  input  logic [HIST_W-1:0] lookHist,
  input  logic              fillValid,
  input  logic [PC_W-1:0]   fillPc,
  input  logic [HIST_W-1:0] fillHist,
  input  logic              fbValid,
  input  logic [PC_W-1:0]   fbPc,
  input  logic [HIST_W-1:0] fbHist,
  input  logic              fbCorrect,
  input  logic              vldQ  [SETS][WAYS],
  input  logic [TAG_W-1:0]  tagQ  [SETS][WAYS],
  input  logic [HIST_W-1:0] histQ [SETS][WAYS],
  input  logic [CNT_W-1:0]  cntQ  [SETS][WAYS],
  output ttbStrobe_t        str,
  output logic [IDX_W-1:0]  lookSet,
  output logic [WAY_W-1:0]  lookWay,
  output logic [IDX_W-1:0]  fillSet,
  output logic [WAY_W-1:0]  fillWay,
  output logic [TAG_W-1:0]  fillTag,
  output logic [IDX_W-1:0]  fbSet,
  output logic [WAY_W-1:0]  fbWay
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [TAG_W-1:0] lookTag, fbTag;
  logic [WAYS-1:0]  lookMatch, lookLive, fillMatch, fbMatch;
  logic             dupFound, freeFound, collide;
  logic [CNT_W-1:0] bestCnt, fbCnt;

  assign lookSet = lookPc[ALIGN +: IDX_W];
  assign fillSet = fillPc[ALIGN +: IDX_W];
  assign fbSet   = fbPc[ALIGN +: IDX_W];
  assign lookTag = lookPc[PC_W-1 -: TAG_W];
  assign fillTag = fillPc[PC_W-1 -: TAG_W];
  assign fbTag   = fbPc[PC_W-1 -: TAG_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lookMatch[w] = vldQ[lookSet][w] && tagQ[lookSet][w] == lookTag && histQ[lookSet][w] == lookHist;
      lookLive[w]  = lookMatch[w] && cntQ[lookSet][w] != '0;
      fillMatch[w] = vldQ[fillSet][w] && tagQ[fillSet][w] == fillTag && histQ[fillSet][w] == fillHist;
      fbMatch[w]   = vldQ[fbSet][w] && tagQ[fbSet][w] == fbTag && histQ[fbSet][w] == fbHist;
    end
  end

  always_comb begin
    lookWay = '0;
    fbWay   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (lookLive[w]) lookWay = WAY_W'(w);
      if (fbMatch[w])  fbWay   = WAY_W'(w);
    end
  end

  // Victim choice: matching entry, then lowest free way, then lowest counter.
  always_comb begin
    fillWay   = '0;
    dupFound  = 1'b0;
    freeFound = 1'b0;
    bestCnt   = cntQ[fillSet][0];
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (fillMatch[w]) begin
        fillWay  = WAY_W'(w);
        dupFound = 1'b1;
      end
    end
    if (!dupFound) begin
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!vldQ[fillSet][w]) begin
          fillWay   = WAY_W'(w);
          freeFound = 1'b1;
        end
      end
      if (!freeFound) begin
        fillWay = '0;
        for (int w = 1; w < WAYS; w++) begin
          if (cntQ[fillSet][w] < bestCnt) begin
            bestCnt = cntQ[fillSet][w];
            fillWay = WAY_W'(w);
          end
        end
      end
    end
  end

  assign fbCnt   = cntQ[fbSet][fbWay];
  assign collide = fillValid && fillSet == fbSet && fillWay == fbWay;

  always_comb begin
    str.fillWe  = fillValid;
    str.fbInc   = fbValid && |fbMatch && fbCorrect && !collide && fbCnt != CNT_MAX;
    str.fbDec   = fbValid && |fbMatch && !fbCorrect && !collide && fbCnt != '0;
    str.lookCap = lookValid;
    str.lookHit = lookValid && |lookLive;
  end

  // R3: overwrite-on-match filling keeps at most one entry per PC/history pair
  a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
    lookValid |-> $onehot0(lookMatch));
endmodule

// File: rtl/ttb_dp.sv
module ttb_dp
  import ttb_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int HIST_W = 8,
  parameter int REG_W  = 5,
  parameter int LIVE_N = 4,
  parameter int SETS   = 32,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 4,
  parameter int ALIGN  = 2,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int TAG_W = PC_W - IDX_W - ALIGN
) (
  input  logic                     clk,
  input  logic                     rst,
  input  ttbStrobe_t               str,
  input  logic [IDX_W-1:0]         lookSet,
  input  logic [WAY_W-1:0]         lookWay,
  input  logic [IDX_W-1:0]         fillSet,
  input  logic [WAY_W-1:0]         fillWay,
  input  logic [TAG_W-1:0]         fillTag,
  input  logic [IDX_W-1:0]         fbSet,
  input  logic [WAY_W-1:0]         fbWay,
  input  logic [PC_W-1:0]          fillEndPc,
  input  logic [HIST_W-1:0]        fillHist,
  input  logic [LIVE_N*REG_W-1:0]  fillRegs,
  input  logic [LIVE_N*DATA_W-1:0] fillVals,
  input  logic [LIVE_N-1:0]        fillLive,
  input  logic [CNT_W-1:0]         fillFreq,
  output logic                     vldQ  [SETS][WAYS],
  output logic [TAG_W-1:0]         tagQ  [SETS][WAYS],
  output logic [HIST_W-1:0]        histQ [SETS][WAYS],
  output logic [CNT_W-1:0]         cntQ  [SETS][WAYS],
  output logic                     respValid,
  output logic                     respHit,
  output logic [PC_W-1:0]          respEndPc,
  output logic [LIVE_N*REG_W-1:0]  respRegs,
  output logic [LIVE_N*DATA_W-1:0] respVals,
  output logic [LIVE_N-1:0]        respLive
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PC_W-1:0]          endQ  [SETS][WAYS];
  logic [LIVE_N*REG_W-1:0]  regsQ [SETS][WAYS];
  logic [LIVE_N*DATA_W-1:0] valsQ [SETS][WAYS];
  logic [LIVE_N-1:0]        liveQ [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          vldQ[s][w] <= 1'b0;
          cntQ[s][w] <= '0;
        end
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respEndPc <= '0;
      respRegs  <= '0;
      respVals  <= '0;
      respLive  <= '0;
    end else begin
      if (str.fbInc)      cntQ[fbSet][fbWay] <= cntQ[fbSet][fbWay] + 1'b1;
      else if (str.fbDec) cntQ[fbSet][fbWay] <= cntQ[fbSet][fbWay] - 1'b1;
      if (str.fillWe) begin
        vldQ[fillSet][fillWay]  <= 1'b1;
        tagQ[fillSet][fillWay]  <= fillTag;
        histQ[fillSet][fillWay] <= fillHist;
        endQ[fillSet][fillWay]  <= fillEndPc;
        regsQ[fillSet][fillWay] <= fillRegs;
        valsQ[fillSet][fillWay] <= fillVals;
        liveQ[fillSet][fillWay] <= fillLive;
        cntQ[fillSet][fillWay]  <= fillFreq;
      end
      respValid <= str.lookCap;
      respHit   <= str.lookHit;
      if (str.lookHit) begin
        respEndPc <= endQ[lookSet][lookWay];
        respRegs  <= regsQ[lookSet][lookWay];
        respVals  <= valsQ[lookSet][lookWay];
        respLive  <= liveQ[lookSet][lookWay];
      end else begin
        respEndPc <= '0;
        respRegs  <= '0;
        respVals  <= '0;
        respLive  <= '0;
      end
    end
  end

  // R7: outside a fill, a counter moves by at most one step and never wraps
  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      a_r7_cnt_step: assert property (@(posedge clk) disable iff (rst)
        !(str.fillWe && fillSet == IDX_W'(s) && fillWay == WAY_W'(w)) |=>
          (cntQ[s][w] == $past(cntQ[s][w])) ||
          ($past(cntQ[s][w]) != CNT_MAX && cntQ[s][w] == $past(cntQ[s][w]) + 1'b1) ||
          ($past(cntQ[s][w]) != '0 && cntQ[s][w] == $past(cntQ[s][w]) - 1'b1));
    end
  end
endmodule

// File: rtl/trace_table.sv
module trace_table
  import ttb_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int HIST_W = 8,
  parameter int REG_W  = 5,
  parameter int LIVE_N = 4,
  parameter int SETS   = 32,
  parameter int WAYS   = 4,
  parameter int CNT_W  = 4,
  parameter int ALIGN  = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fillValid,
  input  logic [PC_W-1:0]          fillPc,
  input  logic [PC_W-1:0]          fillEndPc,
  input  logic [HIST_W-1:0]        fillHist,
  input  logic [LIVE_N*REG_W-1:0]  fillRegs,
  input  logic [LIVE_N*DATA_W-1:0] fillVals,
  input  logic [LIVE_N-1:0]        fillLive,
  input  logic [CNT_W-1:0]         fillFreq,
  input  logic                     lookValid,
  input  logic [PC_W-1:0]          lookPc,
  input  logic [HIST_W-1:0]        lookHist,
  output logic                     respValid,
  output logic                     respHit,
  output logic [PC_W-1:0]          respEndPc,
  output logic [LIVE_N*REG_W-1:0]  respRegs,
  output logic [LIVE_N*DATA_W-1:0] respVals,
  output logic [LIVE_N-1:0]        respLive,
  input  logic                     fbValid,
  input  logic [PC_W-1:0]          fbPc,
  input  logic [HIST_W-1:0]        fbHist,
  input  logic                     fbCorrect
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = PC_W - IDX_W - ALIGN;

  ttbStrobe_t        str;
  logic [IDX_W-1:0]  lookSet, fillSet, fbSet;
  logic [WAY_W-1:0]  lookWay, fillWay, fbWay;
  logic [TAG_W-1:0]  fillTag;
  logic              vldQ  [SETS][WAYS];
  logic [TAG_W-1:0]  tagQ  [SETS][WAYS];
  logic [HIST_W-1:0] histQ [SETS][WAYS];
  logic [CNT_W-1:0]  cntQ  [SETS][WAYS];

  ttb_ctrl #(.PC_W(PC_W), .HIST_W(HIST_W), .SETS(SETS), .WAYS(WAYS),
             .CNT_W(CNT_W), .ALIGN(ALIGN)) u_ctrl (
    .clk(clk), .rst(rst),
    .lookValid(lookValid), .lookPc(lookPc), .lookHist(lookHist),
    .fillValid(fillValid), .fillPc(fillPc), .fillHist(fillHist),
    .fbValid(fbValid), .fbPc(fbPc), .fbHist(fbHist), .fbCorrect(fbCorrect),
    .vldQ(vldQ), .tagQ(tagQ), .histQ(histQ), .cntQ(cntQ),
    .str(str), .lookSet(lookSet), .lookWay(lookWay),
    .fillSet(fillSet), .fillWay(fillWay), .fillTag(fillTag),
    .fbSet(fbSet), .fbWay(fbWay)
  );

  ttb_dp #(.PC_W(PC_W), .DATA_W(DATA_W), .HIST_W(HIST_W), .REG_W(REG_W),
           .LIVE_N(LIVE_N), .SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W),
           .ALIGN(ALIGN)) u_dp (
    .clk(clk), .rst(rst), .str(str),
    .lookSet(lookSet), .lookWay(lookWay),
    .fillSet(fillSet), .fillWay(fillWay), .fillTag(fillTag),
    .fbSet(fbSet), .fbWay(fbWay),
    .fillEndPc(fillEndPc), .fillHist(fillHist), .fillRegs(fillRegs),
    .fillVals(fillVals), .fillLive(fillLive), .fillFreq(fillFreq),
    .vldQ(vldQ), .tagQ(tagQ), .histQ(histQ), .cntQ(cntQ),
    .respValid(respValid), .respHit(respHit), .respEndPc(respEndPc),
    .respRegs(respRegs), .respVals(respVals), .respLive(respLive)
  );

  // R2: result comes exactly one cycle after each request
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (rst)
    lookValid |=> respValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !lookValid |=> !respValid);
  // R3: a hit is only reported inside a result cycle
  a_r3_hit_in_window: assert property (@(posedge clk) disable iff (rst)
    respHit |-> respValid);
endmodule

// File: tb/sim_trace_table.sv
module sim_trace_table;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16, DATA_W = 16, HIST_W = 4, REG_W = 5, LIVE_N = 2;
  localparam int SETS = 4, WAYS = 4, CNT_W = 2, ALIGN = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fillValid = 1'b0;
  logic [PC_W-1:0] fillPc = '0, fillEndPc = '0;
  logic [HIST_W-1:0] fillHist = '0;
  logic [LIVE_N*REG_W-1:0] fillRegs = '0;
  logic [LIVE_N*DATA_W-1:0] fillVals = '0;
  logic [LIVE_N-1:0] fillLive = '0;
  logic [CNT_W-1:0] fillFreq = '0;
  logic lookValid = 1'b0;
  logic [PC_W-1:0] lookPc = '0;
  logic [HIST_W-1:0] lookHist = '0;
  logic respValid, respHit;
  logic [PC_W-1:0] respEndPc;
  logic [LIVE_N*REG_W-1:0] respRegs;
  logic [LIVE_N*DATA_W-1:0] respVals;
  logic [LIVE_N-1:0] respLive;
  logic fbValid = 1'b0;
  logic [PC_W-1:0] fbPc = '0;
  logic [HIST_W-1:0] fbHist = '0;
  logic fbCorrect = 1'b0;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_table #(.PC_W(PC_W), .DATA_W(DATA_W), .HIST_W(HIST_W), .REG_W(REG_W),
                .LIVE_N(LIVE_N), .SETS(SETS), .WAYS(WAYS), .CNT_W(CNT_W),
                .ALIGN(ALIGN)) u0 (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doFill(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] endPc,
                        input logic [HIST_W-1:0] h, input logic [CNT_W-1:0] freq);
    @(negedge clk);
    fillValid = 1'b1; fillPc = pc; fillEndPc = endPc; fillHist = h; fillFreq = freq;
    fillRegs = {5'(pc[6:2]), 5'(pc[11:7])};
    fillVals = {endPc ^ 16'h5A5A, pc ^ 16'hC3C3};
    fillLive = 2'b10 | 2'(pc[4]);
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doLook(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
    @(negedge clk);
    lookValid = 1'b1; lookPc = pc; lookHist = h;
    @(negedge clk);
    lookValid = 1'b0;
  endtask

  task automatic doFb(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h, input logic ok);
    @(negedge clk);
    fbValid = 1'b1; fbPc = pc; fbHist = h; fbCorrect = ok;
    @(negedge clk);
    fbValid = 1'b0;
  endtask

  task automatic expectHit(input string req, input logic [PC_W-1:0] pc,
                           input logic [HIST_W-1:0] h, input logic [PC_W-1:0] endPc);
    doLook(pc, h);
    chk({req, " hit"}, 64'(respHit), 64'd1);
    chk({req, " endPc"}, 64'(respEndPc), 64'(endPc));
  endtask

  task automatic expectMiss(input string req, input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
    doLook(pc, h);
    chk({req, " miss"}, 64'(respHit), 64'd0);
  endtask

  task automatic testReset;
    @(negedge clk);
    chk("R1 respValid idle", 64'(respValid), 64'd0);
    doLook(16'h0104, 4'd5);
    chk("R1 respValid", 64'(respValid), 64'd1);
    chk("R1 empty miss", 64'(respHit), 64'd0);
  endtask

  task automatic testBasic;
    doFill(16'h0104, 16'h0200, 4'd5, 2'd2);
    doLook(16'h0104, 4'd5);
    chk("R2 respValid", 64'(respValid), 64'd1);
    chk("R3 hit", 64'(respHit), 64'd1);
    chk("R3 endPc", 64'(respEndPc), 64'h0200);
    chk("R3 regs", 64'(respRegs), 64'({5'd1, 5'd2}));
    chk("R3 vals", 64'(respVals), 64'({16'h0200 ^ 16'h5A5A, 16'h0104 ^ 16'hC3C3}));
    chk("R3 live", 64'(respLive), 64'd2);
    @(negedge clk);
    chk("R2 respValid drops", 64'(respValid), 64'd0);
    expectHit("R5 align bits ignored", 16'h0107, 4'd5, 16'h0200);
  endtask

  task automatic testMiss;
    doLook(16'h0104, 4'd6);
    chk("R3 history mismatch", 64'(respHit), 64'd0);
    chk("R4 endPc zero", 64'(respEndPc), 64'd0);
    chk("R4 vals zero", 64'(respVals), 64'd0);
    chk("R4 live zero", 64'(respLive), 64'd0);
    expectMiss("R5 same set other tag", 16'h1104, 4'd5);
    expectMiss("R5 other set", 16'h0100, 4'd5);
  endtask

  task automatic testZero;
    doFill(16'h0204, 16'h0300, 4'd5, 2'd0);
    expectMiss("R6 zero counter", 16'h0204, 4'd5);
    doFb(16'h0204, 4'd5, 1'b1);
    expectHit("R7 R9 raised from zero", 16'h0204, 4'd5, 16'h0300);
  endtask

  task automatic testSat;
    for (int i = 0; i < 3; i++) doFb(16'h0104, 4'd5, 1'b1);
    doFb(16'h0104, 4'd5, 1'b0);
    doFb(16'h0104, 4'd5, 1'b0);
    expectHit("R7 upper saturation", 16'h0104, 4'd5, 16'h0200);
    doFb(16'h0104, 4'd5, 1'b0);
    expectMiss("R7 decremented to zero", 16'h0104, 4'd5);
    doFb(16'h0104, 4'd5, 1'b0);
    doFb(16'h0104, 4'd5, 1'b0);
    expectMiss("R7 lower saturation", 16'h0104, 4'd5);
    doFb(16'h0104, 4'd5, 1'b1);
    expectHit("R7 recover", 16'h0104, 4'd5, 16'h0200);
  endtask

  task automatic testReplace;
    doFill(16'h1008, 16'h1100, 4'd1, 2'd3);
    doFill(16'h2008, 16'h2100, 4'd1, 2'd1);
    doFill(16'h3008, 16'h3100, 4'd1, 2'd2);
    doFill(16'h4008, 16'h4100, 4'd1, 2'd1);
    expectHit("R8 free way used", 16'h4008, 4'd1, 16'h4100);
    doFill(16'h5008, 16'h5100, 4'd1, 2'd3);
    expectMiss("R8 lowest count low way evicted", 16'h2008, 4'd1);
    expectHit("R8 tie loser kept", 16'h4008, 4'd1, 16'h4100);
    expectHit("R8 new entry", 16'h5008, 4'd1, 16'h5100);
    expectHit("R8 way0 kept", 16'h1008, 4'd1, 16'h1100);
    doFill(16'h3008, 16'h7770, 4'd1, 2'd2);
    expectHit("R8 overwrite match", 16'h3008, 4'd1, 16'h7770);
    expectHit("R8 no eviction on overwrite", 16'h4008, 4'd1, 16'h4100);
    expectHit("R8 no eviction on overwrite b", 16'h1008, 4'd1, 16'h1100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testBasic();
    testMiss();
    testZero();
    testSat();
    testReplace();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule